// File: doc/BRIEF.md
# Serial Port Clock Generator

This block turns the system clock into the timing strobes a serial port needs. A programmable 16-bit divisor N, written one byte at a time, sets a prescaler whose output is the receiver's sample strobe. The transmitter's bit strobe is taken from that sample strobe: one in sixteen in the normal asynchronous mode, one in eight in the double-speed asynchronous mode.

Two further modes serve synchronous links. As the clock driver, the block toggles an outgoing bit clock on every sample strobe and enables its output driver. As the clock follower, it takes the bit clock from a pin, passes it through two flops, and makes its strobes from the edges it sees. All strobes are single-cycle pulses in the system clock domain, so the shifters can use them as clock enables.

Top module: `sclk_gen`

## Requirements
- R1: In modes 0, 1 and 2 of `clk_mode`, `sample_tick` pulses once every N+1 system clock cycles, where N is the committed divisor.
- R2: With N = 0 in modes 0, 1 and 2, `sample_tick` is high on every cycle.
- R3: In mode 0 (normal asynchronous), `bit_tick` is high on every sixteenth `sample_tick`, and only in a cycle where `sample_tick` is also high.
- R4: In mode 1 (double-speed asynchronous), `bit_tick` is high on every eighth `sample_tick`.
- R5: A write through `div_hi_we` only stages the high byte; the running strobe period does not change.
- R6: A write through `div_lo_we` commits N = {staged high byte, `div_wdata`} and restarts the prescaler and the oversampling count: the first `sample_tick` is high in the (N+1)th cycle after the write cycle, and the first `bit_tick` comes on the sixteenth (mode 0) or eighth (mode 1) sample strobe after it.
- R7: In mode 2 (synchronous clock driver), `xck_oe` is high, `xck_out` is low after a low-byte write and toggles on every `sample_tick` and at no other time, and `bit_tick` is high on the sample strobes where `xck_out` is high (its falling transitions).
- R8: In mode 3 (synchronous clock follower), a level change of `xck_in` present at clock edge E gives a one-cycle `sample_tick` in the cycle after edge E+1; `bit_tick` accompanies only high-to-low changes; `xck_oe` and `xck_out` are low and the prescaler does not reach `sample_tick`.
- R9: With N > 0 in modes 0, 1 and 2, `sample_tick` is never high in two consecutive cycles.
- R10: After reset N is 0, the oversampling count is 0 and `xck_out` is low, so in mode 0 `sample_tick` is high and `bit_tick` low in the first cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_hi_we | input | 1 | Stage `div_wdata` as the divisor high byte |
| div_lo_we | input | 1 | Commit the divisor with `div_wdata` as low byte and restart |
| div_wdata | input | 8 | Divisor byte being written |
| clk_mode | input | 2 | 0 normal async, 1 double-speed async, 2 sync driver, 3 sync follower |
| xck_in | input | 1 | External bit clock used in follower mode |
| sample_tick | output | 1 | Receiver sample strobe |
| bit_tick | output | 1 | Transmitter bit strobe |
| xck_out | output | 1 | Bit clock driven in driver mode |
| xck_oe | output | 1 | Output enable for the bit clock pin |

## Verification
The checker watches, on every cycle, that a bit strobe never appears without a sample strobe, that a zero divisor gives a strobe each cycle, that a nonzero divisor never gives back-to-back strobes, that the driven bit clock only moves on a sample strobe or a restart, and that the pin stays released in follower mode. The exact period N+1, the 16 and 8 sample-strobe grouping, the restart position after a low-byte write, the staging of the high byte and the two-cycle latency from the external clock can only be shown by the bench's scenarios, which compare every cycle against a model of the requirements.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    typedef enum logic [1:0] {
        CKM_ASYNC_X16  = 2'd0,
        CKM_ASYNC_X8   = 2'd1,
        CKM_SYNC_DRIVE = 2'd2,
        CKM_SYNC_FOLLOW = 2'd3
    } ckmode_e;

endpackage

// File: rtl/sclk_prescaler.sv
module sclk_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } pre_t;

    pre_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart || st_q.cnt == '0) begin
            st_d.cnt = div_val;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = (st_q.cnt == '0);

endmodule

// File: rtl/sclk_edge_sync.sv
module sclk_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    output logic any_edge,
    output logic fall_edge
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = ext_in;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign any_edge  = st_q.s2 ^ st_q.prev;
    assign fall_edge = st_q.prev & ~st_q.s2;

endmodule

// File: rtl/sclk_rate_div.sv
module sclk_rate_div
    import sclk_pkg::*;
#(
    parameter int OVS_NORMAL = 16,
    parameter int OVS_DOUBLE = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  ckmode_e mode,
    input  logic    restart,
    input  logic    tick_in,
    input  logic    ext_fall,
    output logic    bit_tick,
    output logic    xck
);

    localparam int PH_W = $clog2(OVS_NORMAL);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            xck;
    } rdiv_t;

    rdiv_t st_d, st_q;
    logic [PH_W-1:0] last_ph;
    logic            is_async;

    always_comb begin
        last_ph  = (mode == CKM_ASYNC_X8) ? PH_W'(OVS_DOUBLE - 1) : PH_W'(OVS_NORMAL - 1);
        is_async = (mode == CKM_ASYNC_X16) || (mode == CKM_ASYNC_X8);
        st_d     = st_q;

        if (restart) begin
            st_d.phase = '0;
        end else if (is_async && tick_in) begin
            st_d.phase = (st_q.phase >= last_ph) ? '0 : st_q.phase + 1'b1;
        end

        if (mode != CKM_SYNC_DRIVE || restart) begin
            st_d.xck = 1'b0;
        end else if (tick_in) begin
            st_d.xck = ~st_q.xck;
        end

        unique case (mode)
            CKM_ASYNC_X16,
            CKM_ASYNC_X8:    bit_tick = tick_in && (st_q.phase >= last_ph);
            CKM_SYNC_DRIVE:  bit_tick = tick_in && st_q.xck;
            CKM_SYNC_FOLLOW: bit_tick = ext_fall;
            default:         bit_tick = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign xck = st_q.xck;

endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
    import sclk_pkg::*;
#(
    parameter int          BYTE_W     = 8,
    parameter int          OVS_NORMAL = 16,
    parameter int          OVS_DOUBLE = 8,
    parameter logic [15:0] RESET_DIV  = 16'd0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        div_hi_we,
    input  logic        div_lo_we,
    input  logic [7:0]  div_wdata,
    input  logic [1:0]  clk_mode,
    input  logic        xck_in,
    output logic        sample_tick,
    output logic        bit_tick,
    output logic        xck_out,
    output logic        xck_oe
);

    localparam int DIV_W = 2 * BYTE_W;

    typedef struct packed {
        logic [BYTE_W-1:0] hi_stage;
        logic [DIV_W-1:0]  div;
    } regs_t;

    regs_t             regs_d, regs_q;
    ckmode_e           mode;
    logic [DIV_W-1:0]  div_cur;
    logic              int_tick;
    logic              ext_any;
    logic              ext_fall;

    assign mode    = ckmode_e'(clk_mode);
    assign div_cur = regs_q.div;

    always_comb begin
        regs_d = regs_q;
        if (div_hi_we) begin
            regs_d.hi_stage = div_wdata[BYTE_W-1:0];
        end
        if (div_lo_we) begin
            regs_d.div = {regs_q.hi_stage, div_wdata[BYTE_W-1:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.hi_stage <= RESET_DIV[DIV_W-1:BYTE_W];
            regs_q.div      <= RESET_DIV[DIV_W-1:0];
        end else begin
            regs_q <= regs_d;
        end
    end

    sclk_prescaler #(
        .DIV_W (DIV_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (div_lo_we),
        .div_val (regs_d.div),
        .tick    (int_tick)
    );

    sclk_edge_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_in    (xck_in),
        .any_edge  (ext_any),
        .fall_edge (ext_fall)
    );

    assign sample_tick = (mode == CKM_SYNC_FOLLOW) ? ext_any : int_tick;

    sclk_rate_div #(
        .OVS_NORMAL (OVS_NORMAL),
        .OVS_DOUBLE (OVS_DOUBLE)
    ) u_rdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .restart  (div_lo_we),
        .tick_in  (sample_tick),
        .ext_fall (ext_fall),
        .bit_tick (bit_tick),
        .xck      (xck_out)
    );

    assign xck_oe = (mode == CKM_SYNC_DRIVE);

endmodule

// File: rtl/sclk_gen_chk.sv
module sclk_gen_chk
    import sclk_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       clk_mode,
    input logic             div_lo_we,
    input logic [DIV_W-1:0] div_value,
    input logic             sample_tick,
    input logic             bit_tick,
    input logic             xck_out,
    input logic             xck_oe
);

    logic follow;
    logic drive;
    assign follow = (clk_mode == 2'(CKM_SYNC_FOLLOW));
    assign drive  = (clk_mode == 2'(CKM_SYNC_DRIVE));

    // R3: a bit strobe is always one of the sample strobes
    assert_bit_in_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sample_tick);

    // R2: zero divisor gives a strobe every cycle
    assert_n0_every_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (div_value == '0 && !follow) |-> sample_tick);

    // R9: nonzero divisor never gives back-to-back strobes
    assert_pulse_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!follow && sample_tick && div_value != '0 && !div_lo_we) |=> (!sample_tick || follow));

    // R7: driven bit clock moves only on a sample strobe or a restart
    assert_drive_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (drive && !sample_tick && !div_lo_we) |=> (!drive || $stable(xck_out)));

    // R8: pin released in follower mode
    assert_follow_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (follow && $past(follow)) |-> (!xck_oe && !xck_out));

endmodule

bind sclk_gen sclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_mode    (clk_mode),
    .div_lo_we   (div_lo_we),
    .div_value   (div_cur),
    .sample_tick (sample_tick),
    .bit_tick    (bit_tick),
    .xck_out     (xck_out),
    .xck_oe      (xck_oe)
);

// File: tb/sclk_gen_tb.sv
module sclk_gen_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hi_we = 1'b0;
    logic       lo_we = 1'b0;
    logic [7:0] wdata = '0;
    logic [1:0] mode = 2'd0;
    logic       xin = 1'b0;
    logic       sample_tick, bit_tick, xck_out, xck_oe;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    bit  hist [0:399];

    always #(CLK_PERIOD/2) clk = ~clk;

    sclk_gen u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .div_hi_we   (hi_we),
        .div_lo_we   (lo_we),
        .div_wdata   (wdata),
        .clk_mode    (mode),
        .xck_in      (xin),
        .sample_tick (sample_tick),
        .bit_tick    (bit_tick),
        .xck_out     (xck_out),
        .xck_oe      (xck_oe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            if (errors <= 20)
                $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr_hi(input logic [7:0] v);
        @(negedge clk);
        hi_we = 1'b1; wdata = v;
        @(negedge clk);
        hi_we = 1'b0;
    endtask

    // leaves the caller in the first cycle after the committing edge
    task automatic wr_lo(input logic [7:0] v);
        @(negedge clk);
        lo_we = 1'b1; wdata = v;
        @(posedge clk);
        @(negedge clk);
        lo_we = 1'b0;
    endtask

    function automatic bit exp_tick(input int k, input int n);
        return (k >= n) && (((k - n) % (n + 1)) == 0);
    endfunction

    // modes 0 and 1: period, restart position, grouping (R1 R2 R3 R4 R6)
    task automatic run_async(input int n, input int md);
        int ovs = (md == 1) ? 8 : 16;
        int span = (ovs + 2) * (n + 1);
        wr_hi(8'(n >> 8));
        mode = 2'(md);
        wr_lo(8'(n & 255));
        for (int k = 0; k < span; k++) begin
            bit t = exp_tick(k, n);
            int j = (k - n) / (n + 1);
            bit b = t && ((j % ovs) == ovs - 1);
            chk(n == 0 ? "R2 sample" : (k == n ? "R6 first sample" : "R1 sample"),
                int'(sample_tick), int'(t));
            chk(md == 1 ? "R4 bit" : (j < ovs ? "R6 first bit" : "R3 bit"),
                int'(bit_tick), int'(b));
            @(negedge clk);
        end
    endtask

    // mode 2: driven bit clock (R7)
    task automatic run_master(input int n);
        int seen = 0;
        wr_hi(8'(n >> 8));
        mode = 2'd2;
        wr_lo(8'(n & 255));
        for (int k = 0; k < 6 * (n + 1); k++) begin
            bit t = exp_tick(k, n);
            bit x = bit'(seen % 2);
            chk("R7 sample", int'(sample_tick), int'(t));
            chk("R7 xck_out", int'(xck_out), int'(x));
            chk("R7 bit", int'(bit_tick), int'(t && x));
            chk("R7 xck_oe", int'(xck_oe), 1);
            if (t) seen++;
            @(negedge clk);
        end
    endtask

    function automatic bit hv(input int i);
        return (i < 0) ? 1'b0 : hist[i];
    endfunction

    // mode 3: follower (R8)
    task automatic run_slave(input int len);
        @(negedge clk);
        xin = 1'b0;
        mode = 2'd3;
        repeat (4) @(negedge clk);
        for (int m = 0; m < len; m++) begin
            bit a = hv(m - 2) ^ hv(m - 3);
            bit f = hv(m - 3) & ~hv(m - 2);
            chk("R8 sample", int'(sample_tick), int'(a));
            chk("R8 bit", int'(bit_tick), int'(f));
            chk("R8 released", int'(xck_oe | xck_out), 0);
            if (m < 12) hist[m] = bit'((m / 3) % 2);
            else hist[m] = (($urandom % 3) == 0) ? ~hv(m - 1) : hv(m - 1);
            xin = hist[m];
            @(negedge clk);
        end
    endtask

    task automatic gap_after_hi(input int n);
        int g = 0;
        while (!sample_tick) @(negedge clk);
        @(negedge clk);
        g = 1;
        while (!sample_tick) begin
            @(negedge clk);
            g++;
        end
        chk("R5 period after high write", g, n + 1);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5C1C);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state: N = 0, mode 0
        chk("R10 sample", int'(sample_tick), 1);
        chk("R10 bit", int'(bit_tick), 0);
        chk("R10 xck_out", int'(xck_out), 0);
        chk("R10 xck_oe", int'(xck_oe), 0);

        run_async(0, 0);
        run_async(0, 1);
        run_async(1, 0);
        run_async(1, 1);
        run_async(255, 1);
        for (int i = 0; i < 6; i++) run_async(int'($urandom % 40), int'($urandom % 2));

        // R5: high byte alone leaves the period unchanged
        run_async(5, 0);
        wr_hi(8'hA5);
        gap_after_hi(5);
        gap_after_hi(5);
        // R6: the staged byte is picked up on the next low write
        run_async(258, 0);

        run_master(0);
        run_master(3);
        for (int i = 0; i < 3; i++) run_master(int'($urandom % 20));

        run_slave(300);
        run_async(2, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule